// File: doc/BRIEF.md
# Sample-Frame Soft-Reset Sequencer with Zero Flags

This block turns a software run/reset control bit into the internal reset for the digital datapath of a stereo sigma-delta converter. When software clears the control bit, the block waits a few sample frames and then asserts the internal datapath reset. While that reset is asserted, it also forces the audio samples to mid-scale, so the analog output settles at the common-mode level. When software sets the bit again, the block waits a shorter number of frames and then releases the reset. The block only sequences the reset. It does not clear any configuration state held elsewhere.

All delays are counted in sample frames. The block takes the raw frame clock, synchronizes it into the system clock domain and turns each rising edge into a one-cycle tick. The frame clock may stop while reset is held, so a cycle-count timeout is used as well. If the request stays low for that long before enough frames have arrived, the reset is asserted anyway.

The two per-channel zero flags are sequenced apart from the internal reset. They rise at once when the request drops. They are held high for a short frame count after the request returns. After that they pass the live zero-detect result of each channel.

Top module: `srs_reset_seq`

## Requirements
- R1: After power-on reset with the request low, `dp_rst`, `zero_force`, `zflag_l` and `zflag_r` are all 1.
- R2: While `run_req` is 0, both zero flags are 1 in the same cycle, whatever the zero-detect inputs are.
- R3: After `run_req` falls, `dp_rst` stays 0 through the first three frame ticks and becomes 1 on the fourth tick (ENTRY_FRAMES = 4). This gives 3 to 4 sample periods.
- R4: After `run_req` rises while in reset, `dp_rst` stays 1 through the first two frame ticks and becomes 0 on the third tick (EXIT_FRAMES = 3). This gives 2 to 3 sample periods.
- R5: After `run_req` rises, the zero flags stay 1 through the first frame tick and are released on the second tick (FLAG_FRAMES = 2). From then on, `zflag_l` equals `zdet_l` and `zflag_r` equals `zdet_r`.
- R6: `zero_force` is 1 exactly while `dp_rst` is 1.
- R7: If `run_req` stays 0 for TIMEOUT_CYCLES system clock cycles without the entry count completing, `dp_rst` becomes 1 even with no frame ticks.
- R8: A change of `run_req` while a delay is pending cancels that delay. Counting restarts from zero for the new direction, and the last requested state wins.
- R9: After the frame clock has stopped for a long time during reset and then restarts, the release sequence of R4 and R5 runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| frame_clk | input | 1 | Raw frame (sample-rate) clock, asynchronous |
| run_req | input | 1 | Software request: 1 = run, 0 = reset |
| zdet_l | input | 1 | Left channel zero-detect result |
| zdet_r | input | 1 | Right channel zero-detect result |
| dp_rst | output | 1 | Internal datapath reset, active high |
| zero_force | output | 1 | Forces mid-scale sample data |
| zflag_l | output | 1 | Left zero flag |
| zflag_r | output | 1 | Right zero flag |

## Verification
The hardest situations to reach are a request that reverses partway through a delay and an entry that must finish with no frame clock at all. The stimulus produces frames one at a time under bench control, so the exact number of ticks seen before a reversal is known. A sweep reverses the request after one, two and three frames, and then checks that a complete fresh count is needed. For the timeout, the bench stops producing frames, drops the request, and checks `dp_rst` just before and just after the cycle limit. It then leaves the frame clock idle for hundreds of cycles before restarting it.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_ENTER = 2'd1,
    SEQ_HELD  = 2'd2,
    SEQ_LEAVE = 2'd3
  } seq_state_t;

endpackage

// File: rtl/srs_frame_sync.sv
module srs_frame_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_in,
  output logic tick
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], frame_in};
    last_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign tick = sync_q[TOP] & ~last_q;

endmodule

// File: rtl/srs_delay_fsm.sv
module srs_delay_fsm
  import srs_pkg::*;
#(
  parameter int ENTRY_FRAMES   = 4,
  parameter int EXIT_FRAMES    = 3,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic tick,
  output logic in_reset
);

  localparam int MAXF = (ENTRY_FRAMES > EXIT_FRAMES) ? ENTRY_FRAMES : EXIT_FRAMES;
  localparam int CW   = $clog2(MAXF + 1);
  localparam int TW   = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_FRAMES - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_FRAMES - 1);
  localparam logic [TW-1:0] TO_LAST    = TW'(TIMEOUT_CYCLES - 1);

  seq_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TW-1:0]   to_q, to_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    to_d    = to_q;
    unique case (state_q)
      SEQ_RUN: begin
        if (!run_req) begin
          state_d = SEQ_ENTER;
          cnt_d   = '0;
          to_d    = '0;
        end
      end
      SEQ_ENTER: begin
        if (run_req) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end else begin
          if (tick) begin
            if (cnt_q == ENTRY_LAST) begin
              state_d = SEQ_HELD;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          if (to_q == TO_LAST) begin
            state_d = SEQ_HELD;
            cnt_d   = '0;
          end else begin
            to_d = to_q + 1'b1;
          end
        end
      end
      SEQ_HELD: begin
        if (run_req) begin
          state_d = SEQ_LEAVE;
          cnt_d   = '0;
        end
      end
      SEQ_LEAVE: begin
        if (!run_req) begin
          state_d = SEQ_HELD;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q == EXIT_LAST) begin
            state_d = SEQ_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HELD;
      cnt_q   <= '0;
      to_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      to_q    <= to_d;
    end
  end

  assign in_reset = (state_q == SEQ_HELD) || (state_q == SEQ_LEAVE);

endmodule

// File: rtl/srs_zero_flags.sv
module srs_zero_flags #(
  parameter int NUM_CH      = 2,
  parameter int FLAG_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              tick,
  input  logic [NUM_CH-1:0] zdet,
  output logic [NUM_CH-1:0] zflag
);

  localparam int FW = $clog2(FLAG_FRAMES + 1);
  localparam logic [FW-1:0] FLAG_LAST = FW'(FLAG_FRAMES - 1);

  logic          hold_q, hold_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (!run_req) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q && tick) begin
      if (cnt_q == FLAG_LAST) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign zflag[g] = hold_q | ~run_req | zdet[g];
  end

endmodule

// File: rtl/srs_reset_seq.sv
module srs_reset_seq #(
  parameter int SYNC_STAGES    = 2,
  parameter int ENTRY_FRAMES   = 4,
  parameter int EXIT_FRAMES    = 3,
  parameter int FLAG_FRAMES    = 2,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic run_req,
  input  logic zdet_l,
  input  logic zdet_r,
  output logic dp_rst,
  output logic zero_force,
  output logic zflag_l,
  output logic zflag_r
);

  localparam int NUM_CH = 2;

  logic              frame_tick;
  logic              in_reset;
  logic [NUM_CH-1:0] zdet_vec;
  logic [NUM_CH-1:0] zflag_vec;

  srs_frame_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_in (frame_clk),
    .tick     (frame_tick)
  );

  srs_delay_fsm #(
    .ENTRY_FRAMES   (ENTRY_FRAMES),
    .EXIT_FRAMES    (EXIT_FRAMES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_req  (run_req),
    .tick     (frame_tick),
    .in_reset (in_reset)
  );

  assign zdet_vec = {zdet_r, zdet_l};

  srs_zero_flags #(
    .NUM_CH      (NUM_CH),
    .FLAG_FRAMES (FLAG_FRAMES)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_req (run_req),
    .tick    (frame_tick),
    .zdet    (zdet_vec),
    .zflag   (zflag_vec)
  );

  assign dp_rst     = in_reset;
  assign zero_force = in_reset;
  assign zflag_l    = zflag_vec[0];
  assign zflag_r    = zflag_vec[1];

endmodule

// File: rtl/srs_reset_seq_chk.sv
module srs_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run_req,
  input logic frame_tick,
  input logic dp_rst,
  input logic zero_force,
  input logic zflag_l,
  input logic zflag_r
);

  a_r2_flags_high_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |-> (zflag_l && zflag_r));

  a_r3_enter_only_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_rst) |-> !$past(run_req));

  a_r4_leave_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst) |-> ($past(run_req) && $past(frame_tick)));

  a_r5_flag_l_fall_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zflag_l) |-> run_req);

  a_r5_flag_r_fall_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zflag_r) |-> run_req);

  a_r6_force_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_rst) |-> zero_force);

endmodule

bind srs_reset_seq srs_reset_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_req    (run_req),
  .frame_tick (frame_tick),
  .dp_rst     (dp_rst),
  .zero_force (zero_force),
  .zflag_l    (zflag_l),
  .zflag_r    (zflag_r)
);

// File: tb/tb_srs_reset_seq.sv
module tb_srs_reset_seq;

  localparam int TO_CYC = 200;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic run_req = 1'b0;
  logic zdet_l = 1'b0;
  logic zdet_r = 1'b0;
  logic dp_rst, zero_force, zflag_l, zflag_r;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  srs_reset_seq #(
    .TIMEOUT_CYCLES (TO_CYC)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clk  (frame_clk),
    .run_req    (run_req),
    .zdet_l     (zdet_l),
    .zdet_r     (zdet_r),
    .dp_rst     (dp_rst),
    .zero_force (zero_force),
    .zflag_l    (zflag_l),
    .zflag_r    (zflag_r)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_rst(input logic exp, input string tag);
    chk(dp_rst, exp, tag);
    chk(zero_force, exp, "R6 zero_force tracks dp_rst");
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int n);
    repeat (n) begin
      frame_clk = 1'b1;
      step(HALF);
      frame_clk = 1'b0;
      step(HALF);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 power-on state
    chk_rst(1'b1, "R1 dp_rst after power-on");
    chk(zflag_l, 1'b1, "R1 zflag_l after power-on");
    chk(zflag_r, 1'b1, "R1 zflag_r after power-on");

    // R4 / R5 first release
    run_req = 1'b1;
    frames(1);
    chk(zflag_l, 1'b1, "R5 flag held after 1 tick");
    chk_rst(1'b1, "R4 held after 1 tick");
    frames(1);
    chk(zflag_l, 1'b0, "R5 flag_l released after 2 ticks");
    chk(zflag_r, 1'b0, "R5 flag_r released after 2 ticks");
    chk_rst(1'b1, "R4 held after 2 ticks");
    frames(1);
    chk_rst(1'b0, "R4 released after 3 ticks");

    // R5 sweep of zero-detect inputs in run
    for (int v = 0; v < 4; v++) begin
      zdet_l = v[0];
      zdet_r = v[1];
      step(1);
      chk(zflag_l, v[0], "R5 flag_l follows zdet_l");
      chk(zflag_r, v[1], "R5 flag_r follows zdet_r");
    end

    // R2 flags immediate on request low
    zdet_l = 1'b0;
    zdet_r = 1'b0;
    step(1);
    run_req = 1'b0;
    #1;
    chk(zflag_l, 1'b1, "R2 flag_l immediate");
    chk(zflag_r, 1'b1, "R2 flag_r immediate");
    for (int v = 0; v < 4; v++) begin
      zdet_l = v[0];
      zdet_r = v[1];
      step(1);
      chk(zflag_l, 1'b1, "R2 flag_l high any zdet");
      chk(zflag_r, 1'b1, "R2 flag_r high any zdet");
    end
    zdet_l = 1'b0;
    zdet_r = 1'b0;

    // R3 entry count
    for (int k = 1; k <= 4; k++) begin
      frames(1);
      chk_rst((k == 4) ? 1'b1 : 1'b0, "R3 entry after tick count");
    end

    run_req = 1'b1;
    frames(2);
    chk_rst(1'b1, "R4 held 2 ticks");
    frames(1);
    chk_rst(1'b0, "R4 released 3 ticks");

    // R8 abort of entry after k ticks, then fresh count
    for (int k = 1; k <= 3; k++) begin
      run_req = 1'b0;
      frames(k);
      chk_rst(1'b0, "R8 pending entry");
      run_req = 1'b1;
      step(4);
      chk_rst(1'b0, "R8 entry aborted");
      frames(2);
      run_req = 1'b0;
      frames(3);
      chk_rst(1'b0, "R8 fresh entry 3 ticks");
      frames(1);
      chk_rst(1'b1, "R8 fresh entry 4 ticks");
      run_req = 1'b1;
      frames(3);
      chk_rst(1'b0, "R8 exit after sweep");
    end

    // R8 abort of exit, then fresh count
    run_req = 1'b0;
    frames(4);
    chk_rst(1'b1, "R8 entered");
    run_req = 1'b1;
    frames(2);
    chk_rst(1'b1, "R8 pending exit");
    run_req = 1'b0;
    step(4);
    chk_rst(1'b1, "R8 exit aborted");
    run_req = 1'b1;
    frames(2);
    chk_rst(1'b1, "R8 fresh exit 2 ticks");
    frames(1);
    chk_rst(1'b0, "R8 fresh exit 3 ticks");

    // R7 timeout with no frames
    run_req = 1'b0;
    step(TO_CYC - 20);
    chk_rst(1'b0, "R7 before timeout");
    step(30);
    chk_rst(1'b1, "R7 after timeout");

    // R9 long stop then recovery
    step(500);
    chk_rst(1'b1, "R9 held while stopped");
    run_req = 1'b1;
    step(300);
    chk_rst(1'b1, "R9 waits for frames");
    chk(zflag_l, 1'b1, "R9 flag held without frames");
    frames(2);
    chk(zflag_l, 1'b0, "R9 flag_l released after restart");
    chk(zflag_r, 1'b0, "R9 flag_r released after restart");
    chk_rst(1'b1, "R9 still held 2 ticks");
    frames(1);
    chk_rst(1'b0, "R9 released after restart");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule